// File: doc/BRIEF.md
# Configurable Bit-Rate Line Encoder

This block sits between a serial bit source and a carrier modulator. Every timing event is counted in cycles of the carrier-rate clock. A 3-bit rate code sets how many carrier cycles one data bit lasts. The block pulls one data bit per bit period through a single-cycle request strobe. It shapes each bit with one of four line codes: level, differential biphase, Manchester or inverted Manchester.

A sensor input acts as a final polarity control. While the sensor is high, the coded stream leaves the block unchanged. While it is low, every output level is flipped, and this takes effect in the same cycle.

The data side is a pull interface with no back-pressure. The source must present the next bit on `data_in` in every cycle in which `data_req` is high. The block samples `data_in` on the clock edge that ends that cycle. The source cannot stall the block, and the block never waits for the source. The bit period that follows reset carries the bit value 0.

Top module: `bitrate_encoder`

## Requirements
- R1: Reset is active-low and synchronous. During reset and in the first cycle after it, `bit_start` is 1, `data_req` is 0 and the current bit is 0.
- R2: `rate_sel` codes 0 to 7 give bit periods of 8, 16, 40, 32, 50, 64, 100 and 128 carrier cycles. `bit_start` pulses once every period.
- R3: `data_req` is high only in the last cycle of each bit period. The `data_in` value sampled at the end of that cycle becomes the bit of the next period.
- R4: With `enc_sel` = 0 (level code), the raw output equals the bit value for the whole period.
- R5: With `enc_sel` = 2 (Manchester), the raw output equals the bit value in the first N/2 cycles of the period and its complement in the remaining cycles.
- R6: With `enc_sel` = 3 (inverted Manchester), the raw output is the complement of the Manchester output.
- R7: With `enc_sel` = 1 (differential biphase), the raw level starts at 0 after reset and toggles at every bit boundary. It also toggles at cycle N/2 of a period whose bit is 0.
- R8: `enc_out` equals the raw output while `sensor` is 1. It equals the complement of the raw output while `sensor` is 0, in the same cycle.
- R9: `bit_start` is high exactly in the first cycle of each bit period, which is the cycle after `data_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 3 | Cycles-per-bit code |
| enc_sel | input | 2 | Line code select: 0 level, 1 differential biphase, 2 Manchester, 3 inverted Manchester |
| sensor | input | 1 | 1 = pass the stream, 0 = invert the stream |
| data_in | input | 1 | Next data bit, sampled at the end of a data_req cycle |
| data_req | output | 1 | Single-cycle fetch strobe in the last cycle of a period |
| enc_out | output | 1 | Encoded bit-level stream |
| bit_start | output | 1 | High in the first cycle of each bit period |

## Verification
Each rate code is run with a short level-coded pattern. Checking the strobe positions in every cycle tells the eight period lengths apart and shows any off-by-one in the counter. Alternating and run-of-identical-bit patterns are sent through Manchester, inverted Manchester and differential biphase. These patterns separate a missing mid-bit transition from a missing boundary transition, and in the differential code they show whether the mid toggle depends on the bit being 0. A constant low sensor and a sensor toggling every few cycles show that the inversion is applied to the whole stream in the same cycle.

// File: rtl/enc_pkg.sv
package enc_pkg;
  localparam int PERIOD_W = 8;

  typedef enum logic [1:0] {
    ENC_LEVEL = 2'd0,
    ENC_DIFF  = 2'd1,
    ENC_MAN   = 2'd2,
    ENC_IMAN  = 2'd3
  } enc_mode_e;

  function automatic logic [PERIOD_W-1:0] period_of(input logic [2:0] code);
    case (code)
      3'd0:    period_of = 8'd8;
      3'd1:    period_of = 8'd16;
      3'd2:    period_of = 8'd40;
      3'd3:    period_of = 8'd32;
      3'd4:    period_of = 8'd50;
      3'd5:    period_of = 8'd64;
      3'd6:    period_of = 8'd100;
      default: period_of = 8'd128;
    endcase
  endfunction
endpackage

// File: rtl/bit_timer.sv
module bit_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  output logic             bit_start,
  output logic             data_req,
  output logic             mid_next,
  output logic             second_half
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half;

  assign half        = period >> 1;
  assign bit_start   = (cnt == '0);
  assign data_req    = (cnt >= period - 1'b1);
  assign mid_next    = (cnt == half - 1'b1);
  assign second_half = (cnt >= half);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (data_req) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  // R9
  start_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |=> bit_start);

  // R3
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |=> !data_req);
endmodule

// File: rtl/line_coder.sv
module line_coder
  import enc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  enc_mode_e mode,
  input  logic      data_in,
  input  logic      data_req,
  input  logic      mid_next,
  input  logic      second_half,
  output logic      raw
);
  logic cur_bit;
  logic diff_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n)        cur_bit <= 1'b0;
    else if (data_req) cur_bit <= data_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    diff_lvl <= 1'b0;
    else if (data_req)             diff_lvl <= ~diff_lvl;
    else if (mid_next && !cur_bit) diff_lvl <= ~diff_lvl;
  end

  always_comb begin
    case (mode)
      ENC_LEVEL: raw = cur_bit;
      ENC_DIFF:  raw = diff_lvl;
      ENC_MAN:   raw = second_half ? ~cur_bit : cur_bit;
      default:   raw = second_half ? cur_bit : ~cur_bit;
    endcase
  end

  // R4
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ENC_LEVEL && $stable(mode) && !$past(data_req)) |-> $stable(raw));

  // R5
  man_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(second_half) && mode == ENC_MAN && $stable(mode)) |-> raw != $past(raw));

  // R7
  diff_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ENC_DIFF && $stable(mode) && $past(data_req)) |-> raw != $past(raw));
endmodule

// File: rtl/bitrate_encoder.sv
module bitrate_encoder #(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate_sel,
  input  logic [1:0] enc_sel,
  input  logic       sensor,
  input  logic       data_in,
  output logic       data_req,
  output logic       enc_out,
  output logic       bit_start
);
  logic [CNT_W-1:0] period;
  logic             mid_next;
  logic             second_half;
  logic             raw;

  assign period = CNT_W'(enc_pkg::period_of(rate_sel));

  bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .period      (period),
    .bit_start   (bit_start),
    .data_req    (data_req),
    .mid_next    (mid_next),
    .second_half (second_half)
  );

  line_coder u_coder (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (enc_pkg::enc_mode_e'(enc_sel)),
    .data_in     (data_in),
    .data_req    (data_req),
    .mid_next    (mid_next),
    .second_half (second_half),
    .raw         (raw)
  );

  assign enc_out = sensor ? raw : ~raw;

  // R8
  sensor_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(sensor) && $stable(raw)) |-> enc_out != $past(enc_out));
endmodule

// File: tb/sim_bitrate_encoder.sv
`timescale 1ns/1ps
module sim_bitrate_encoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic [1:0] enc_sel = 2'd0;
  logic       sensor = 1'b1;
  logic       data_in = 1'b0;
  logic       data_req, enc_out, bit_start;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  bitrate_encoder u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .enc_sel(enc_sel),
    .sensor(sensor), .data_in(data_in), .data_req(data_req),
    .enc_out(enc_out), .bit_start(bit_start)
  );

  function automatic int bench_period(input int code);
    case (code)
      0: return 8;   1: return 16;  2: return 40;  3: return 32;
      4: return 50;  5: return 64;  6: return 100; default: return 128;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input int k);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, k, act, exp);
    end
  endtask

  // sens_mode: 0 high, 1 low, 2 toggles every 7 cycles
  task automatic run_case(input int rate, input int enc, input int sens_mode,
                          input int nbits, input logic [31:0] pat, input string tag);
    int n = bench_period(rate);
    int half = n / 2;
    logic lvl = 1'b0;
    rate_sel = 3'(rate);
    enc_sel  = 2'(enc);
    sensor   = 1'b1;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < (nbits + 1) * n; k++) begin
      int p = k / n;
      int pos = k % n;
      logic b = (p == 0) ? 1'b0 : pat[p-1];
      logic s = (sens_mode == 0) ? 1'b1 : (sens_mode == 1) ? 1'b0 : (((k / 7) % 2) == 0);
      logic r;
      sensor  = s;
      data_in = (p < 32) ? pat[p] : 1'b0;
      case (enc)
        0: r = b;
        1: r = lvl;
        2: r = (pos < half) ? b : ~b;
        default: r = (pos < half) ? ~b : b;
      endcase
      #1;
      if (k == 0) begin
        check("R1 bit_start after reset", bit_start, 1'b1, k);
        check("R1 data_req after reset", data_req, 1'b0, k);
      end
      check({"R2 R9 bit_start ", tag}, bit_start, (pos == 0), k);
      check({"R3 data_req ", tag}, data_req, (pos == n - 1), k);
      check({tag, " enc_out"}, enc_out, s ? r : ~r, k);
      if (pos == n - 1) lvl = ~lvl;
      else if (pos == half - 1 && !b) lvl = ~lvl;
      @(negedge clk);
    end
  endtask

  task automatic t_rates;
    for (int c = 0; c < 8; c++) run_case(c, 0, 0, 3, 32'b101, "R2 R4");
  endtask
  task automatic t_level;   run_case(0, 0, 0, 12, 32'hC35, "R4");         endtask
  task automatic t_man;     run_case(3, 2, 0, 10, 32'h2B5, "R5");         endtask
  task automatic t_iman;    run_case(4, 3, 0, 10, 32'h0F3, "R6");         endtask
  task automatic t_diff_a;  run_case(1, 1, 0, 16, 32'hF00F, "R7");        endtask
  task automatic t_diff_b;  run_case(7, 1, 0, 6, 32'h2A, "R7");           endtask
  task automatic t_sens_lo; run_case(0, 0, 1, 10, 32'h1A6, "R8");         endtask
  task automatic t_sens_tg; run_case(6, 2, 2, 5, 32'h19, "R8 R5");        endtask
  task automatic t_sens_df; run_case(2, 1, 1, 6, 32'h35, "R8 R7");        endtask

  initial begin
    t_rates;
    t_level;
    t_man;
    t_iman;
    t_diff_a;
    t_diff_b;
    t_sens_lo;
    t_sens_tg;
    t_sens_df;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 150000);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule